// File: doc/BRIEF.md
# Digit-Serial Programme Fetch Sequencer

This block loads the division programme of a frequency synthesizer divider one digit at a time from an external programme source. A slow programme clock, sampled in the system clock domain, steps an eight-state sequence. It has seven fetch periods and one idle state. Each fetch period pulls one active-low address strobe low, so that the external source can present the matching pair of digits.

In periods 0 to 5 the block takes two negative-logic digits, A and B. It subtracts B and a running borrow from A. The lowest digit is in base M and the five upper digits are decimal. Period 6 carries the configuration: the first-stage ratio, the half-channel mode and the modulus M. The final borrow is available after period 5, and a slave-mode flag is raised when the digit pattern for cascading is seen. All results move to the outputs together when the sequence leaves period 6. The divider chain that uses these results is not part of this block.

An enable input allows the sequence to stop part-way. The sequence then parks in the configuration period, where the configuration inputs may be changed freely.

Top module: `prog_fetch_seq`

## Requirements
- R1: After reset the sequence is idle (state 7), with every address strobe high. On each rising edge of `prog_clk` seen while `prog_en` is high, the state moves 7→0→1→…→6→7. In period k (0..6) only `addr_n[k]` is low. In state 7 all strobes are high.
- R2: `load_stb` is high exactly while the sampled `prog_clk` is low and the state is a fetch period (0..6). In periods 0..5 the digits are captured in the first system clock cycle of that low phase.
- R3: A rising `prog_clk` edge seen while `prog_en` is low leaves the state unchanged. The next falling edge then puts the sequence in period 6 and captures no digit. A later rising edge with `prog_en` high resumes the sequence from period 6.
- R4: The `a_n` and `b_n` pins are inverted to form digit values. The borrow-in is taken from `sin` only in period 0, where high means borrow. `sin` is ignored in every other period.
- R5: Digit 0 is (A0−B0−bin), with M added when that value is negative, which then produces a borrow. Digits 1..5 are (Ak−Bk−borrow), with 10 added and a borrow produced when the value is negative. All results are taken modulo 16. In `digits_o`, digit k sits at bits [4k+3:4k].
- R6: `borrow_o` changes only at the period 5 capture. It is then set to the borrow out of digit 5, which means the full result wrapped by M·10^5.
- R7: In period 6, `b_n[3:2]` at pin level selects the ratio on `ratio_o`: 00→1, 01→2, 10→5, 11→10.
- R8: In period 6, `b_n[1:0]` at pin level selects the half-channel mode. 00 gives `half_en_o`=0. 01 gives `half_en_o`=1 with `half_off_o`=0. 11 gives `half_en_o`=1 with `half_off_o`=1. 10 gives `test_o`=1 with both other flags at 0.
- R9: In period 6, M is the inverted `a_n`, except that an all-high pin value means M=16. `m_o` always holds a value from 1 to 16.
- R10: `slave_o` is set when A2=11, B2=10 and A3, A4, B3, B4 and B5 are all 0.
- R11: The digits, the configuration outputs and `slave_o` change only on the rising edge that leaves period 6. They change there all together. Their reset values are: digits 0, `m_o`=16, `ratio_o`=1, flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_clk | input | 1 | Programme clock, sampled by `clk` |
| prog_en | input | 1 | Programme enable; low pauses the sequence |
| a_n | input | 4 | Digit A, negative logic (M in period 6) |
| b_n | input | 4 | Digit B, negative logic (configuration bits in period 6) |
| sin | input | 1 | Borrow-in, read in period 0 |
| addr_n | output | 7 | Active-low fetch period strobes |
| load_stb | output | 1 | High while the data must be stable |
| digits_o | output | 24 | Committed internal digits n0..n5 |
| borrow_o | output | 1 | Final subtractor borrow |
| slave_o | output | 1 | Cascade slave pattern detected |
| m_o | output | 5 | Committed modulus M (1..16) |
| ratio_o | output | 4 | Committed first-stage ratio |
| half_en_o | output | 1 | Half-channel counter enabled (H=2) |
| half_off_o | output | 1 | Half-channel offset selected |
| test_o | output | 1 | Half-channel test state selected |

## Verification
The hardest case to reach is a pause. The enable must drop before a rising programme-clock edge, and the following falling edge must then send the sequence to period 6 without capturing a digit. When this happens, digits 3 to 5 from the previous programme stay in staging and are committed with the new ones. The stimulus stops one programme after period 2, checks the strobe pattern, and lets the per-cycle reference model confirm the mixed old and new digits. Negative results are driven separately for M=7 and for M=16, so that the base-M correction of digit 0 and the wrap of the decimal digits are both exercised.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

   // half-channel selection codes as read at the pins in period 6
   typedef enum logic [1:0] {
      HC_OFF  = 2'b00,
      HC_EVEN = 2'b01,
      HC_TEST = 2'b10,
      HC_ODD  = 2'b11
   } half_code_e;

   function automatic logic [3:0] ratio_decode(input logic [1:0] sel);
      case (sel)
         2'b00:   return 4'd1;
         2'b01:   return 4'd2;
         2'b10:   return 4'd5;
         default: return 4'd10;
      endcase
   endfunction

endpackage

// File: rtl/fetch_seq_ctrl.sv
module fetch_seq_ctrl #(
   parameter int NPER = 7,
   localparam int CW = $clog2(NPER + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            prog_clk,
   input  logic            prog_en,
   output logic [CW-1:0]   per,
   output logic [NPER-1:0] addr_n,
   output logic            load_stb,
   output logic            dig_cap,
   output logic            cfg_load,
   output logic            commit
);
   localparam logic [CW-1:0] IDLE = CW'(NPER);
   localparam logic [CW-1:0] CFG  = CW'(NPER - 1);

   logic pc_q, halt_q, rise, fall;

   assign rise = prog_clk & ~pc_q;
   assign fall = ~prog_clk & pc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q   <= 1'b0;
         halt_q <= 1'b0;
         per    <= IDLE;
      end else begin
         pc_q <= prog_clk;
         if (rise) begin
            if (prog_en) begin
               per    <= (per == IDLE) ? '0 : per + 1'b1;
               halt_q <= 1'b0;
            end else begin
               halt_q <= 1'b1;
            end
         end else if (fall && halt_q) begin
            per    <= CFG;
            halt_q <= 1'b0;
         end
      end
   end

   assign dig_cap  = fall & ~halt_q & (per < CFG);
   assign cfg_load = (per == CFG) & ~pc_q;
   assign commit   = rise & prog_en & (per == CFG);
   assign load_stb = ~pc_q & (per != IDLE);

   for (genvar k = 0; k < NPER; k++) begin : g_addr
      assign addr_n[k] = (per != CW'(k));
   end

   assert_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~addr_n));
   assert_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && prog_en) |=> (per != $past(per)));
   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && !prog_en) |=> (per == $past(per)));
   assert_park_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && halt_q) |=> (per == CFG));
   assert_strobe_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(load_stb) |-> $fell(pc_q) || $changed(per));

endmodule

// File: rtl/fetch_digit_sub.sv
module fetch_digit_sub #(
   parameter int DW       = 4,
   parameter int NDIG     = 6,
   parameter int DEC_BASE = 10,
   localparam int CW = $clog2(NDIG + 2)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cap,
   input  logic [CW-1:0]      per,
   input  logic [DW-1:0]      a_n,
   input  logic [DW-1:0]      b_n,
   input  logic               sin,
   input  logic               commit,
   input  logic [DW-1:0]      m_low,
   output logic [NDIG*DW-1:0] digits_o,
   output logic               borrow_o,
   output logic               slave_o
);
   initial begin
      assert (DW >= 4 && DEC_BASE <= (1 << DW) && NDIG >= 6)
         else $error("fetch_digit_sub: unsupported parameters");
   end

   localparam logic [CW-1:0] LAST = CW'(NDIG - 1);

   logic [DW-1:0] a, b;
   logic          bin, neg;
   logic [DW:0]   diff;
   logic [DW-1:0] dec_val;
   logic          brw_q, neg0, slv_s;
   logic [DW-1:0] raw0;
   logic [DW-1:0] staged [NDIG];

   assign a       = ~a_n;
   assign b       = ~b_n;
   assign bin     = (per == '0) ? sin : brw_q;
   assign diff    = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, bin};
   assign neg     = diff[DW];
   assign dec_val = neg ? diff[DW-1:0] + DW'(DEC_BASE) : diff[DW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         brw_q    <= 1'b0;
         neg0     <= 1'b0;
         raw0     <= '0;
         borrow_o <= 1'b0;
         slv_s    <= 1'b0;
      end else if (cap) begin
         brw_q <= neg;
         if (per == '0) begin
            raw0 <= diff[DW-1:0];
            neg0 <= neg;
         end
         if (per == LAST) borrow_o <= neg;
         case (per)
            CW'(2): slv_s <= (a == DW'(11)) && (b == DW'(10));
            CW'(3), CW'(4): slv_s <= slv_s && (a == '0) && (b == '0);
            CW'(5): slv_s <= slv_s && (b == '0);
            default: ;
         endcase
      end
   end

   assign staged[0] = raw0 + (neg0 ? m_low : '0);

   for (genvar k = 1; k < NDIG; k++) begin : g_dig
      logic [DW-1:0] stg;
      always_ff @(posedge clk) begin
         if (!rst_n)                    stg <= '0;
         else if (cap && per == CW'(k)) stg <= dec_val;
      end
      assign staged[k] = stg;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         digits_o <= '0;
         slave_o  <= 1'b0;
      end else if (commit) begin
         for (int k = 0; k < NDIG; k++) digits_o[k*DW +: DW] <= staged[k];
         slave_o <= slv_s;
      end
   end

   assert_digits_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(digits_o) && $stable(slave_o));
   assert_borrow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(cap && per == LAST) |=> $stable(borrow_o));

endmodule

// File: rtl/fetch_cfg_dec.sv
module fetch_cfg_dec
   import fetch_pkg::*;
#(
   parameter int DW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_load,
   input  logic          commit,
   input  logic [DW-1:0] a_n,
   input  logic [3:0]    b_pin,
   output logic [DW-1:0] m_low,
   output logic [DW:0]   m_o,
   output logic [3:0]    ratio_o,
   output logic          half_en_o,
   output logic          half_off_o,
   output logic          test_o
);
   localparam logic [DW:0] M_FULL = {1'b1, {DW{1'b0}}};

   logic [DW:0] m_stg;
   logic [3:0]  b_stg;
   logic [DW:0] m_next;
   half_code_e  hc;

   assign m_next = (~a_n == '0) ? M_FULL : {1'b0, ~a_n};
   assign m_low  = m_stg[DW-1:0];
   assign hc     = half_code_e'(b_stg[1:0]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_stg <= M_FULL;
         b_stg <= '0;
      end else if (cfg_load) begin
         m_stg <= m_next;
         b_stg <= b_pin;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_o        <= M_FULL;
         ratio_o    <= 4'd1;
         half_en_o  <= 1'b0;
         half_off_o <= 1'b0;
         test_o     <= 1'b0;
      end else if (commit) begin
         m_o        <= m_stg;
         ratio_o    <= ratio_decode(b_stg[3:2]);
         half_en_o  <= (hc == HC_EVEN) || (hc == HC_ODD);
         half_off_o <= (hc == HC_ODD);
         test_o     <= (hc == HC_TEST);
      end
   end

   assert_m_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (m_o != '0) && (m_o <= M_FULL));
   assert_half_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(test_o && (half_en_o || half_off_o)) && !(half_off_o && !half_en_o));
   assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(m_o) && $stable(ratio_o) && $stable(test_o));

endmodule

// File: rtl/prog_fetch_seq.sv
module prog_fetch_seq #(
   parameter int DW   = 4,
   parameter int NDIG = 6,
   localparam int NPER = NDIG + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               prog_clk,
   input  logic               prog_en,
   input  logic [DW-1:0]      a_n,
   input  logic [DW-1:0]      b_n,
   input  logic               sin,
   output logic [NPER-1:0]    addr_n,
   output logic               load_stb,
   output logic [NDIG*DW-1:0] digits_o,
   output logic               borrow_o,
   output logic               slave_o,
   output logic [DW:0]        m_o,
   output logic [3:0]         ratio_o,
   output logic               half_en_o,
   output logic               half_off_o,
   output logic               test_o
);
   localparam int CW = $clog2(NPER + 1);

   logic [CW-1:0] per;
   logic          dig_cap, cfg_load, commit;
   logic [DW-1:0] m_low;

   fetch_seq_ctrl #(.NPER(NPER)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .prog_clk(prog_clk), .prog_en(prog_en),
      .per(per), .addr_n(addr_n), .load_stb(load_stb),
      .dig_cap(dig_cap), .cfg_load(cfg_load), .commit(commit)
   );

   fetch_digit_sub #(.DW(DW), .NDIG(NDIG), .DEC_BASE(10)) u_sub (
      .clk(clk), .rst_n(rst_n), .cap(dig_cap), .per(per),
      .a_n(a_n), .b_n(b_n), .sin(sin), .commit(commit), .m_low(m_low),
      .digits_o(digits_o), .borrow_o(borrow_o), .slave_o(slave_o)
   );

   fetch_cfg_dec #(.DW(DW)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .commit(commit),
      .a_n(a_n), .b_pin(b_n[3:0]), .m_low(m_low), .m_o(m_o),
      .ratio_o(ratio_o), .half_en_o(half_en_o), .half_off_o(half_off_o),
      .test_o(test_o)
   );

endmodule

// File: tb/test_prog_fetch_seq.sv
module test_prog_fetch_seq;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic        prog_clk = 1'b0, prog_en = 1'b1, sin = 1'b0;
   logic [3:0]  a_n = 4'hF, b_n = 4'hF;
   logic [6:0]  addr_n;
   logic        load_stb, borrow_o, slave_o, half_en_o, half_off_o, test_o;
   logic [23:0] digits_o;
   logic [4:0]  m_o;
   logic [3:0]  ratio_o;

   int nchk = 0, nerr = 0;

   always #2.5 clk = ~clk;

   prog_fetch_seq i_prog_fetch_seq (
      .clk(clk), .rst_n(rst_n), .prog_clk(prog_clk), .prog_en(prog_en),
      .a_n(a_n), .b_n(b_n), .sin(sin), .addr_n(addr_n), .load_stb(load_stb),
      .digits_o(digits_o), .borrow_o(borrow_o), .slave_o(slave_o), .m_o(m_o),
      .ratio_o(ratio_o), .half_en_o(half_en_o), .half_off_o(half_off_o),
      .test_o(test_o)
   );

   // ---------------- behavioural reference model ----------------
   int st, pcp, halted, brw, raw0, neg0, slv_s, m_s, bcfg_s;
   int stg[6];
   int e_dig[6];
   int e_brw, e_slv, e_m, e_ratio, e_hen, e_hoff, e_test;

   function automatic int ratio_of(int sel);
      case (sel)
         0: return 1;
         1: return 2;
         2: return 5;
         default: return 10;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         st = 7; pcp = 0; halted = 0; brw = 0; raw0 = 0; neg0 = 0; slv_s = 0;
         m_s = 16; bcfg_s = 0;
         foreach (stg[k]) begin stg[k] = 0; e_dig[k] = 0; end
         e_brw = 0; e_slv = 0; e_m = 16; e_ratio = 1; e_hen = 0; e_hoff = 0; e_test = 0;
      end else begin
         int r, f, av, bv, bi, d;
         r = (prog_clk && !pcp) ? 1 : 0;
         f = (!prog_clk && pcp) ? 1 : 0;
         if (f && !halted && st < 6) begin
            av = 15 - a_n; bv = 15 - b_n;
            bi = (st == 0) ? int'(sin) : brw;
            d  = av - bv - bi;
            if (st == 0) begin raw0 = d; neg0 = (d < 0); end
            else stg[st] = (d < 0) ? (d + 10) & 15 : d & 15;
            brw = (d < 0);
            if (st == 5) e_brw = brw;
            if (st == 2) slv_s = (av == 11 && bv == 10);
            if (st == 3 || st == 4) slv_s = slv_s && av == 0 && bv == 0;
            if (st == 5) slv_s = slv_s && bv == 0;
         end
         if (r && prog_en && st == 6) begin
            e_dig[0] = (raw0 + (neg0 ? m_s : 0)) & 15;
            for (int k = 1; k < 6; k++) e_dig[k] = stg[k];
            e_slv = slv_s; e_m = m_s;
            e_ratio = ratio_of(bcfg_s >> 2);
            e_hen  = ((bcfg_s & 3) == 1 || (bcfg_s & 3) == 3);
            e_hoff = ((bcfg_s & 3) == 3);
            e_test = ((bcfg_s & 3) == 2);
         end
         if (st == 6 && !pcp) begin
            m_s = (a_n == 4'hF) ? 16 : 15 - a_n;
            bcfg_s = b_n;
         end
         if (r) begin
            if (prog_en) begin st = (st + 1) % 8; halted = 0; end
            else halted = 1;
         end else if (f && halted) begin
            st = 6; halted = 0;
         end
         pcp = prog_clk;
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // compare every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R1", "addr_n", addr_n, (st < 7) ? (7'h7F & ~(7'd1 << st)) : 7'h7F);
         chk("R2", "load_stb", load_stb, (!pcp && st != 7));
         for (int k = 0; k < 6; k++) chk("R5", "digit", digits_o[4*k +: 4], e_dig[k]);
         chk("R6", "borrow_o", borrow_o, e_brw);
         chk("R10", "slave_o", slave_o, e_slv);
         chk("R9", "m_o", m_o, e_m);
         chk("R7", "ratio_o", ratio_o, e_ratio);
         chk("R8", "half_en_o", half_en_o, e_hen);
         chk("R8", "half_off_o", half_off_o, e_hoff);
         chk("R8", "test_o", test_o, e_test);
      end
   end

   // ---------------- stimulus ----------------
   task automatic pc_pulse();
      prog_clk = 1'b1;
      repeat (3) @(negedge clk);
      prog_clk = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic set_cfg(input int m, input int bcfg);
      a_n = (m == 16) ? 4'hF : ~4'(m);
      b_n = 4'(bcfg);
   endtask

   task automatic run_prog(input int a[6], input int b[6], input int bin, input int m, input int bcfg);
      for (int k = 0; k < 7; k++) begin
         if (k < 6) begin
            a_n = ~4'(a[k]); b_n = ~4'(b[k]);
            sin = (k == 0) ? 1'(bin) : ~1'(bin);  // R4: ignored outside period 0
         end else set_cfg(m, bcfg);
         pc_pulse();
      end
      pc_pulse();   // leave period 6: commit
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11", "reset digits", digits_o, 0);
      chk("R11", "reset m_o", m_o, 16);
      chk("R11", "reset ratio", ratio_o, 1);
      chk("R1", "reset addr_n", addr_n, 7'h7F);

      run_prog('{0,0,0,0,0,0}, '{0,0,0,0,0,0}, 0, 10, 4'b1100);
      chk("R5", "zero program", digits_o, 0);

      run_prog('{3,4,5,6,7,8}, '{1,2,3,4,5,6}, 1, 12, 4'b1001);
      chk("R4", "inverted digits with borrow-in", digits_o, 24'h222221);
      chk("R7", "ratio 5", ratio_o, 5);

      run_prog('{0,0,0,0,0,0}, '{1,0,0,0,0,0}, 0, 7, 4'b0111);
      chk("R5", "base-M wrap", digits_o, 24'h999996);
      chk("R6", "final borrow", borrow_o, 1);

      run_prog('{0,0,11,0,0,0}, '{0,0,10,0,0,0}, 0, 16, 4'b0010);
      chk("R10", "slave pattern", slave_o, 1);
      chk("R9", "all-high M", m_o, 16);
      chk("R8", "test state", test_o, 1);

      run_prog('{2,0,0,0,0,0}, '{5,0,0,0,0,0}, 0, 16, 4'b0001);
      chk("R5", "M=16 wrap", digits_o, 24'h99999D);

      // R3 pause: run periods 0..2, then stop
      for (int k = 0; k < 3; k++) begin
         a_n = ~4'(k + 5); b_n = ~4'(k); sin = 1'b0;
         pc_pulse();
      end
      prog_en = 1'b0;
      a_n = ~4'd9; b_n = ~4'd9;
      pc_pulse();
      chk("R3", "parked in period 6", addr_n, 7'h3F);
      set_cfg(3, 4'b0101);
      repeat (3) @(negedge clk);
      prog_en = 1'b1;
      pc_pulse();
      chk("R3", "resumed to idle", addr_n, 7'h7F);
      chk("R3", "M after pause", m_o, 3);

      for (int n = 0; n < 12; n++) begin
         int a[6], b[6];
         foreach (a[k]) begin
            a[k] = $urandom_range(0, 9); b[k] = $urandom_range(0, 9);
         end
         run_prog(a, b, $urandom_range(0, 1), $urandom_range(1, 16), $urandom_range(0, 15));
      end

      repeat (4) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule